// File: doc/BRIEF.md
# Pipelined SRAM Read Output Stage with Selectable Deselect Latency

This block is the read-data output path of a 36-bit pipelined synchronous burst SRAM. Chip enable and the read/write command are captured on every rising clock edge. A read captured on edge k returns the array word presented on `rd_data` just before edge k+2. That word is driven from edge k+2 for one cycle, which gives the three-cycle first access and the one-cycle-per-beat flow of a 3-1-1-1 burst. The memory array, drive strength and sleep behaviour are outside this block. The array only supplies `rd_data` in the cycle before the output register samples it.

The static input `dual_sel` sets how long the outputs stay on after a read when a deselect follows it. With `dual_sel` low (single-cycle deselect, the state when the input is tied off or left at its default low level), the deselect takes one stage fewer than a read, so the drivers turn off straight after the last data cycle. With `dual_sel` high (dual-cycle deselect), the deselect goes through as many stages as a read. The drivers then keep the last word on the bus for one more full cycle before they turn off.

A write turns the drivers off for its output-stage cycle, so the write data never collides with read data. The asynchronous output enable `oe` gates both the drive flag and the data at once, whatever state the pipeline is in.

Top module: `sram_rd_outpath`

## Requirements
- R1: During and after reset, with no read issued, `dq_drive` is 0 and `dq_out` is 0.
- R2: A read (`ce`=1, `we`=0) sampled on edge k makes `dq_drive`=1 from edge k+2, and `dq_out` then equals the `rd_data` value present at edge k+2.
- R3: Reads sampled on consecutive edges keep `dq_drive` at 1 in every cycle, and each cycle shows the word belonging to its own read, in issue order, with no gap.
- R4: With `dual_sel`=0, a read on edge k followed by a deselect (`ce`=0) on edge k+1 gives `dq_drive`=0 from edge k+3.
- R5: With `dual_sel`=1, the same sequence keeps `dq_drive`=1 with the unchanged word through edge k+3, and `dq_drive`=0 from edge k+4.
- R6: A write (`ce`=1, `we`=1) sampled on edge j gives `dq_drive`=0 from edge j+2 in either mode. A read directly before the write gets no extra hold cycle.
- R7: `oe`=0 forces `dq_drive` and `dq_out` to 0 without waiting for a clock edge. When `oe` returns to 1, the pipeline state is visible again unchanged.
- R8: In dual-cycle mode, a deselect that does not directly follow a read adds no drive cycle.
- R9: `dq_out` is 0 whenever `dq_drive` is 0.
- R10: When `ce`=0, `we` is ignored and the cycle acts as a deselect, including the dual-cycle hold after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_sel | input | 1 | Static mode: 0 single-cycle deselect, 1 dual-cycle deselect |
| ce | input | 1 | Synchronous chip enable; 0 is a deselect |
| we | input | 1 | Synchronous command when enabled: 1 write, 0 read |
| oe | input | 1 | Asynchronous output enable, active high |
| rd_data | input | 36 | Word from the memory array, sampled by the output register |
| dq_out | output | 36 | Data bus value, 0 when not driven |
| dq_drive | output | 1 | Output driver enable for the current cycle |

## Verification
The bench goes after the cycle in which drive ends after a read that a deselect follows. A design with both modes on the same latency would either cut the dual-cycle hold or leave the single-cycle bus on a cycle too long. It checks a write directly after a read and a disabled cycle with `we` high. These catch a design that lets a write inherit the read's hold, or that decodes the command without `ce`. It also runs unbroken read streams, where a stage miscount shows up as a gap or a word shifted by one beat. Finally it toggles `oe` mid-cycle, which exposes an enable that was registered instead of combinational, or one that clobbers the pipeline.

// File: rtl/sramq_pkg.sv
package sramq_pkg;
    typedef enum logic [1:0] {
        OP_OFF = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;
endpackage

// File: rtl/sramq_cmd_pipe.sv
module sramq_cmd_pipe
    import sramq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic we,
    output op_e  op_s2,
    output op_e  op_s3
);
    typedef struct packed {
        op_e s1;
        op_e s2;
        op_e s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.s1 = ce ? (we ? OP_WR : OP_RD) : OP_OFF;
        pipe_d.s2 = pipe_q.s1;
        pipe_d.s3 = pipe_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '{s1: OP_OFF, s2: OP_OFF, s3: OP_OFF};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign op_s2 = pipe_q.s2;
    assign op_s3 = pipe_q.s3;

    // R10: a disabled cycle reaches stage two as a deselect whatever we is
    p_ce_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> ##2 (op_s2 == OP_OFF));
endmodule

// File: rtl/sramq_out_stage.sv
module sramq_out_stage
    import sramq_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_sel,
    input  op_e               op_s2,
    input  op_e               op_s3,
    input  logic [DATA_W-1:0] rd_data,
    output logic              drive_q,
    output logic [DATA_W-1:0] data_q
);
    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        unique case (op_s2)
            OP_RD: begin
                out_d.drive = 1'b1;
                out_d.data  = rd_data;
            end
            OP_WR: begin
                out_d.drive = 1'b0;
            end
            default: begin
                // deselect: dual mode keeps the last read word one more cycle
                out_d.drive = dual_sel && (op_s3 == OP_RD);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{drive: 1'b0, data: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign drive_q = out_q.drive;
    assign data_q  = out_q.data;

    p_rd_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_s2 == OP_RD) |=> drive_q);

    p_wr_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_s2 == OP_WR) |=> !drive_q);

    p_scd_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_sel && op_s2 == OP_OFF) |=> !drive_q);

    p_dcd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_sel && op_s2 == OP_OFF && op_s3 == OP_RD) |=> (drive_q && $stable(data_q)));

    p_no_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_s2 == OP_OFF && op_s3 != OP_RD) |=> !drive_q);
endmodule

// File: rtl/sram_rd_outpath.sv
module sram_rd_outpath
    import sramq_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_sel,
    input  logic              ce,
    input  logic              we,
    input  logic              oe,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);
    op_e               op_s2, op_s3;
    logic              drv_reg;
    logic [DATA_W-1:0] word_reg;

    sramq_cmd_pipe u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .we    (we),
        .op_s2 (op_s2),
        .op_s3 (op_s3)
    );

    sramq_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .dual_sel (dual_sel),
        .op_s2    (op_s2),
        .op_s3    (op_s3),
        .rd_data  (rd_data),
        .drive_q  (drv_reg),
        .data_q   (word_reg)
    );

    // asynchronous output enable gates flag and bus without a register
    assign dq_drive = drv_reg & oe;
    assign dq_out   = dq_drive ? word_reg : '0;

    // R2: a captured read has the output register driving three samples later
    p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !we) |-> ##3 drv_reg);
endmodule

// File: tb/sim_sram_rd_outpath.sv
module sim_sram_rd_outpath;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dual_sel = 1'b0;
    logic          ce = 1'b0;
    logic          we = 1'b0;
    logic          oe = 1'b1;
    logic [DW-1:0] rd_data = '0;
    logic [DW-1:0] dq_out;
    logic          dq_drive;

    int  vecs = 0;
    int  bad  = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    sram_rd_outpath #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .dual_sel(dual_sel), .ce(ce), .we(we),
        .oe(oe), .rd_data(rd_data), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    task automatic step(input logic c, input logic w, input logic [DW-1:0] d);
        ce = c; we = w; rd_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic edrv, input logic [DW-1:0] edat);
        vecs++;
        if (dq_drive !== edrv || dq_out !== edat) begin
            bad++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                     tag, dq_drive, dq_out, edrv, edat);
        end
    endtask

    task automatic flush();
        repeat (4) step(1'b0, 1'b0, '0);
    endtask

    task automatic t_reset();
        chk("R1 in reset", 1'b0, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(1'b0, 1'b0, 36'hF_FFFF_FFFF);
        step(1'b0, 1'b0, 36'hF_FFFF_FFFF);
        chk("R1 after reset", 1'b0, '0);
    endtask

    task automatic t_scd_single();
        dual_sel = 1'b0; flush();
        step(1'b1, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 36'h1_2345_6789);
        chk("R2 read latency", 1'b1, 36'h1_2345_6789);
        step(1'b0, 1'b0, 36'hA_AAAA_AAAA);
        chk("R4 single-cycle off", 1'b0, '0);
    endtask

    task automatic t_dcd_single();
        dual_sel = 1'b1; flush();
        step(1'b1, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 36'h3_C3C3_C3C3);
        chk("R2 read latency dual", 1'b1, 36'h3_C3C3_C3C3);
        step(1'b0, 1'b0, 36'h5_5555_5555);
        chk("R5 dual hold", 1'b1, 36'h3_C3C3_C3C3);
        step(1'b0, 1'b0, 36'h6_6666_6666);
        chk("R5 dual off", 1'b0, '0);
    endtask

    task automatic t_b2b();
        dual_sel = 1'b0; flush();
        step(1'b1, 1'b0, '0);
        step(1'b1, 1'b0, '0);
        step(1'b1, 1'b0, 36'h0_0000_0011);
        chk("R3 beat0", 1'b1, 36'h0_0000_0011);
        step(1'b1, 1'b0, 36'h0_0000_0022);
        chk("R3 beat1", 1'b1, 36'h0_0000_0022);
        step(1'b0, 1'b0, 36'h8_0000_0033);
        chk("R3 beat2", 1'b1, 36'h8_0000_0033);
        step(1'b0, 1'b0, 36'hF_0000_0044);
        chk("R3 beat3", 1'b1, 36'hF_0000_0044);
        step(1'b0, 1'b0, 36'h7_7777_7777);
        chk("R4 off after stream", 1'b0, '0);
    endtask

    task automatic t_write();
        dual_sel = 1'b1; flush();
        step(1'b1, 1'b0, '0);
        step(1'b1, 1'b1, '0);
        step(1'b0, 1'b0, 36'h2_0F0F_0F0F);
        chk("R6 read before write", 1'b1, 36'h2_0F0F_0F0F);
        step(1'b0, 1'b0, 36'h9_9999_9999);
        chk("R6 write slot off", 1'b0, '0);
        step(1'b0, 1'b0, '0);
        chk("R6 stays off", 1'b0, '0);
    endtask

    task automatic t_ce_ignores_we();
        dual_sel = 1'b1; flush();
        step(1'b1, 1'b0, '0);
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b0, 36'h4_BEEF_0001);
        chk("R10 read data", 1'b1, 36'h4_BEEF_0001);
        step(1'b0, 1'b1, 36'h1_1111_1111);
        chk("R10 disabled we acts as deselect", 1'b1, 36'h4_BEEF_0001);
        step(1'b0, 1'b0, '0);
        chk("R10 off", 1'b0, '0);
    endtask

    task automatic t_no_hold();
        dual_sel = 1'b1; flush();
        step(1'b1, 1'b1, '0);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 36'hC_0000_0C0C);
        chk("R8 write then deselect", 1'b0, '0);
        step(1'b0, 1'b0, 36'hD_0000_0D0D);
        chk("R8 no drive from deselect", 1'b0, '0);
    endtask

    task automatic t_oe();
        dual_sel = 1'b0; flush();
        step(1'b1, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 36'hE_1234_0000);
        chk("R2 before oe", 1'b1, 36'hE_1234_0000);
        oe = 1'b0; #1;
        chk("R7 oe low mid-cycle", 1'b0, '0);
        chk("R9 bus zero when not driven", 1'b0, '0);
        oe = 1'b1; #1;
        chk("R7 oe restored", 1'b1, 36'hE_1234_0000);
        oe = 1'b0;
        step(1'b1, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 36'hB_0000_0B0B);
        chk("R7 held off during read", 1'b0, '0);
        oe = 1'b1; #1;
        chk("R7 pipeline kept", 1'b1, 36'hB_0000_0B0B);
        step(1'b0, 1'b0, '0);
        chk("R9 off", 1'b0, '0);
    endtask

    initial begin
        #1;
        t_reset();
        t_scd_single();
        t_dcd_single();
        t_b2b();
        t_write();
        t_ce_ignores_we();
        t_no_hold();
        t_oe();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            vecs++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule